// File: doc/BRIEF.md
# Shared-RAM Host Access Port

This block lets a host processor reach the private memory of an I/O coprocessor through four byte-wide registers. The host loads a 16-bit pointer as two separate bytes, then moves data through a single data window. Every data access touches the byte the pointer names. When auto-advance is enabled, the pointer steps by one after each data access, so a whole buffer can be streamed through the one window without reloading the pointer.

The memory is a dual-port byte array. A simple coprocessor-side port stands in for the coprocessor core and can read and write the same bytes. A control/status register gathers the following:

- a run enable that halts the coprocessor when cleared;
- the auto-advance enable;
- a pass-through (bypass) enable;
- a doorbell toward the coprocessor;
- two event flags toward the host.

The coprocessor raises the event flags with one-cycle strobes. The host acknowledges them by writing ones to them. The two flags share one host interrupt line. A typical use is a liveness probe: the coprocessor writes 0xFF to an agreed byte, and the host reads it back and then writes 0 there.

Top module: `sram_host_port`

## Requirements
- R1: After reset the pointer reads 0x0000, the control/status register reads 0x00, and hostIrq, cpRun, cpBypass and cpDoorbell are all low.
- R2: Register select (hostAddr) encoding: 0 is the pointer low byte, 1 is the pointer high byte, 2 is the data window, 3 is control/status. A write to select 0 or 1 replaces only that byte of the pointer, and reading them returns the pointer bytes.
- R3: A host write to the data window stores the byte at memory index pointer[MEM_AW-1:0], where the coprocessor port can read it.
- R4: A host read (hostRd) of any register updates hostRdata on the clock edge that samples the read. A data-window read returns the byte at the current pointer.
- R5: With the auto-advance bit (control bit 1) set, each data-window read or write increments the full 16-bit pointer by one, with carry from the low byte into the high byte and wrap from 0xFFFF to 0x0000. With the bit clear, the pointer is unchanged.
- R6: Control bits 0 (run), 1 (auto-advance) and 2 (bypass) take the written value on every control write, including writes that also acknowledge flags. cpRun follows bit 0 and cpBypass follows bit 2.
- R7: Control bit 3 (doorbell) is set by writing 1 to it; writing 0 leaves it unchanged. It clears on the edge that samples cpDoorbellAck, unless the same edge also sets it. cpDoorbell shows the bit.
- R8: Event flags sit at control bits 4 and 5. A strobe on cpIntSet[n] sets flag n. Writing 1 to its bit clears it, and writing 0 leaves it unchanged. A strobe on the same edge as the clearing write leaves the flag set. Bits 7:6 read 0.
- R9: hostIrq is high exactly when at least one event flag is set.
- R10: The coprocessor port writes on cpEn&&cpWe and returns read data on cpRdata one cycle after cpEn&&!cpWe. If host and coprocessor write the same byte on one edge, the host value is kept.
- R11: A byte of 0xFF written by the coprocessor is read by the host as 0xFF. A 0 written there by the host is then read as 0 by the coprocessor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWr | input | 1 | Host register write strobe |
| hostRd | input | 1 | Host register read strobe (ignored when hostWr is high) |
| hostAddr | input | 2 | Host register select |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Registered host read data |
| hostIrq | output | 1 | Shared host interrupt |
| cpEn | input | 1 | Coprocessor memory access enable |
| cpWe | input | 1 | Coprocessor write enable |
| cpAddr | input | MEM_AW | Coprocessor byte address |
| cpWdata | input | 8 | Coprocessor write data |
| cpRdata | output | 8 | Coprocessor read data, one cycle after request |
| cpIntSet | input | 2 | One-cycle strobes that set the host event flags |
| cpDoorbellAck | input | 1 | Coprocessor acknowledge of the doorbell |
| cpDoorbell | output | 1 | Doorbell toward the coprocessor |
| cpRun | output | 1 | Run enable toward the coprocessor |
| cpBypass | output | 1 | Bypass enable toward the coprocessor |

## Verification
Every one of the 256 control byte values is written and read back against an arithmetic model. This separates the plain bits, the sticky doorbell and the write-one-to-clear flags. The whole memory is filled through the streaming window with an index-derived pattern and read back both through the coprocessor port and through the window. This shows whether pointer advance, memory indexing and the two ports agree. Pointers set just below the 0x0100 carry and at 0xFFFF tell correct 16-bit advance apart from byte-only or missing advance. Same-edge cases (a flag strobe with its clearing write, and host and coprocessor writes to one byte) tell the chosen priorities apart from their opposites.

// File: rtl/srhp_pkg.sv
package srhp_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 16;
  localparam int HI_W    = ADDR_W - DATA_W;
  localparam int NUM_INT = 2;

  localparam int BIT_RUN      = 0;
  localparam int BIT_AUTOINC  = 1;
  localparam int BIT_BYPASS   = 2;
  localparam int BIT_DOORBELL = 3;
  localparam int BIT_INT_BASE = 4;

  typedef enum logic [1:0] {
    SEL_ADDR_LO = 2'd0,
    SEL_ADDR_HI = 2'd1,
    SEL_DATA    = 2'd2,
    SEL_CTRL    = 2'd3
  } regSel_e;

  // strobes from control to datapath for one host access
  typedef struct packed {
    logic    loadLo;
    logic    loadHi;
    logic    dataWr;
    logic    dataRd;
    logic    advance;
    logic    capture;
    regSel_e rdSel;
  } hostStrobe_t;
endpackage

// File: rtl/srhp_ctrl.sv
module srhp_ctrl
  import srhp_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostWr,
  input  logic                hostRd,
  input  logic [1:0]          hostAddr,
  input  logic [DATA_W-1:0]   hostWdata,
  input  logic [NUM_INT-1:0]  cpIntSet,
  input  logic                cpDoorbellAck,
  output hostStrobe_t         strobe,
  output logic [DATA_W-1:0]   ctrlByte,
  output logic                runBit,
  output logic                bypassBit,
  output logic                doorbellBit,
  output logic                hostIrq
);
  regSel_e              sel;
  logic                 rdEn;
  logic                 ctrlWr;
  logic                 autoIncBit;
  logic [NUM_INT-1:0]   intFlag;

  // decode one host access into datapath strobes
  always_comb begin
    sel            = regSel_e'(hostAddr);
    rdEn           = hostRd && !hostWr;
    ctrlWr         = hostWr && (sel == SEL_CTRL);
    strobe.loadLo  = hostWr && (sel == SEL_ADDR_LO);
    strobe.loadHi  = hostWr && (sel == SEL_ADDR_HI);
    strobe.dataWr  = hostWr && (sel == SEL_DATA);
    strobe.dataRd  = rdEn && (sel == SEL_DATA);
    strobe.advance = autoIncBit && (strobe.dataWr || strobe.dataRd);
    strobe.capture = rdEn;
    strobe.rdSel   = sel;
  end

  // plain control bits: taken as written
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit     <= 1'b0;
      autoIncBit <= 1'b0;
      bypassBit  <= 1'b0;
    end else if (ctrlWr) begin
      runBit     <= hostWdata[BIT_RUN];
      autoIncBit <= hostWdata[BIT_AUTOINC];
      bypassBit  <= hostWdata[BIT_BYPASS];
    end
  end

  // doorbell: host sets, coprocessor acknowledge clears, set wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      doorbellBit <= 1'b0;
    else if (ctrlWr && hostWdata[BIT_DOORBELL])
      doorbellBit <= 1'b1;
    else if (cpDoorbellAck)
      doorbellBit <= 1'b0;
  end

  // event flags: strobe sets, write-one clears, strobe wins
  for (genvar g = 0; g < NUM_INT; g++) begin : gIntFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        intFlag[g] <= 1'b0;
      else if (cpIntSet[g])
        intFlag[g] <= 1'b1;
      else if (ctrlWr && hostWdata[BIT_INT_BASE + g])
        intFlag[g] <= 1'b0;
    end

    // R8: a set strobe always leaves the flag set
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
      cpIntSet[g] |=> intFlag[g]);
  end

  assign hostIrq = |intFlag;

  always_comb begin
    ctrlByte                              = '0;
    ctrlByte[BIT_RUN]                     = runBit;
    ctrlByte[BIT_AUTOINC]                 = autoIncBit;
    ctrlByte[BIT_BYPASS]                  = bypassBit;
    ctrlByte[BIT_DOORBELL]                = doorbellBit;
    ctrlByte[BIT_INT_BASE +: NUM_INT]     = intFlag;
  end

  // R6: run bit follows the written value
  a_r6_run_written: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (runBit == $past(hostWdata[BIT_RUN])));

  // R7: acknowledge without a new ring clears the doorbell
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (cpDoorbellAck && !(ctrlWr && hostWdata[BIT_DOORBELL])) |=> !doorbellBit);

  // R9: the host interrupt never rises without a set strobe
  a_r9_no_spurious_irq: assert property (@(posedge clk) disable iff (!rstN)
    (!hostIrq && (cpIntSet == '0)) |=> !hostIrq);
endmodule

// File: rtl/srhp_datapath.sv
module srhp_datapath
  import srhp_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  hostStrobe_t         strobe,
  input  logic [DATA_W-1:0]   hostWdata,
  input  logic [DATA_W-1:0]   ctrlByte,
  input  logic                cpEn,
  input  logic                cpWe,
  input  logic [MEM_AW-1:0]   cpAddr,
  input  logic [DATA_W-1:0]   cpWdata,
  output logic [DATA_W-1:0]   cpRdata,
  output logic [DATA_W-1:0]   hostRdata
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [ADDR_W-1:0]  addrReg;
  logic [MEM_AW-1:0]  memIdx;
  logic [DATA_W-1:0]  mem [DEPTH];

  assign memIdx = addrReg[MEM_AW-1:0];

  // 16-bit pointer with byte loads and auto-advance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      addrReg <= '0;
    else if (strobe.loadLo)
      addrReg[DATA_W-1:0] <= hostWdata;
    else if (strobe.loadHi)
      addrReg[ADDR_W-1:DATA_W] <= hostWdata[HI_W-1:0];
    else if (strobe.advance)
      addrReg <= addrReg + 1'b1;
  end

  // dual-port byte array; host write placed last so it wins a collision
  always_ff @(posedge clk) begin
    if (cpEn && cpWe)
      mem[cpAddr] <= cpWdata;
    if (strobe.dataWr)
      mem[memIdx] <= hostWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cpRdata <= '0;
    else if (cpEn && !cpWe)
      cpRdata <= mem[cpAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      hostRdata <= '0;
    else if (strobe.capture) begin
      unique case (strobe.rdSel)
        SEL_ADDR_LO: hostRdata <= addrReg[DATA_W-1:0];
        SEL_ADDR_HI: hostRdata <= addrReg[ADDR_W-1:DATA_W];
        SEL_DATA:    hostRdata <= mem[memIdx];
        SEL_CTRL:    hostRdata <= ctrlByte;
      endcase
    end
  end

  // R5: an advancing data access steps the pointer by one
  a_r5_advance: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> (addrReg == $past(addrReg) + 16'd1));

  // R5: a data access without advance keeps the pointer
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.dataWr || strobe.dataRd) && !strobe.advance) |=> $stable(addrReg));

  // R10: host value survives a same-byte write collision
  a_r10_host_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dataWr && cpEn && cpWe && (cpAddr == memIdx))
      |=> (mem[$past(memIdx)] == $past(hostWdata)));
endmodule

// File: rtl/sram_host_port.sv
module sram_host_port
  import srhp_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [1:0]        hostAddr,
  input  logic [7:0]        hostWdata,
  output logic [7:0]        hostRdata,
  output logic              hostIrq,
  input  logic              cpEn,
  input  logic              cpWe,
  input  logic [MEM_AW-1:0] cpAddr,
  input  logic [7:0]        cpWdata,
  output logic [7:0]        cpRdata,
  input  logic [1:0]        cpIntSet,
  input  logic              cpDoorbellAck,
  output logic              cpDoorbell,
  output logic              cpRun,
  output logic              cpBypass
);
  hostStrobe_t        strobe;
  logic [DATA_W-1:0]  ctrlByte;

  srhp_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .hostWr       (hostWr),
    .hostRd       (hostRd),
    .hostAddr     (hostAddr),
    .hostWdata    (hostWdata),
    .cpIntSet     (cpIntSet),
    .cpDoorbellAck(cpDoorbellAck),
    .strobe       (strobe),
    .ctrlByte     (ctrlByte),
    .runBit       (cpRun),
    .bypassBit    (cpBypass),
    .doorbellBit  (cpDoorbell),
    .hostIrq      (hostIrq)
  );

  srhp_datapath #(.MEM_AW(MEM_AW)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .hostWdata(hostWdata),
    .ctrlByte (ctrlByte),
    .cpEn     (cpEn),
    .cpWe     (cpWe),
    .cpAddr   (cpAddr),
    .cpWdata  (cpWdata),
    .cpRdata  (cpRdata),
    .hostRdata(hostRdata)
  );
endmodule

// File: tb/sram_host_port_tb.sv
module sram_host_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_AW = 8;
  localparam int DEPTH = 1 << MEM_AW;

  logic clk = 1'b0;
  logic rstN;
  logic hostWr, hostRd;
  logic [1:0] hostAddr;
  logic [7:0] hostWdata, hostRdata;
  logic hostIrq;
  logic cpEn, cpWe;
  logic [MEM_AW-1:0] cpAddr;
  logic [7:0] cpWdata, cpRdata;
  logic [1:0] cpIntSet;
  logic cpDoorbellAck, cpDoorbell, cpRun, cpBypass;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_host_port #(.MEM_AW(MEM_AW)) dut_i (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .hostIrq(hostIrq), .cpEn(cpEn), .cpWe(cpWe), .cpAddr(cpAddr),
    .cpWdata(cpWdata), .cpRdata(cpRdata), .cpIntSet(cpIntSet),
    .cpDoorbellAck(cpDoorbellAck), .cpDoorbell(cpDoorbell),
    .cpRun(cpRun), .cpBypass(cpBypass)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 8'hFF);
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // all tasks enter and leave at a falling edge
  task automatic hostWrite(input logic [1:0] sel, input logic [7:0] d);
    hostWr = 1'b1; hostAddr = sel; hostWdata = d;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] sel, output logic [7:0] d);
    hostRd = 1'b1; hostAddr = sel;
    @(negedge clk);
    hostRd = 1'b0;
    d = hostRdata;
  endtask

  task automatic cpWrite(input logic [MEM_AW-1:0] a, input logic [7:0] d);
    cpEn = 1'b1; cpWe = 1'b1; cpAddr = a; cpWdata = d;
    @(negedge clk);
    cpEn = 1'b0; cpWe = 1'b0;
  endtask

  task automatic cpRead(input logic [MEM_AW-1:0] a, output logic [7:0] d);
    cpEn = 1'b1; cpWe = 1'b0; cpAddr = a;
    @(negedge clk);
    cpEn = 1'b0;
    d = cpRdata;
  endtask

  task automatic setPtr(input logic [15:0] p);
    hostWrite(2'd0, p[7:0]);
    hostWrite(2'd1, p[15:8]);
  endtask

  initial begin
    logic [7:0] rd, lo, hi;
    logic dbModel;
    logic [1:0] intModel;
    hostWr = 0; hostRd = 0; hostAddr = 0; hostWdata = 0;
    cpEn = 0; cpWe = 0; cpAddr = 0; cpWdata = 0; cpIntSet = 0; cpDoorbellAck = 0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", hostIrq, 0);
    check("R1 run", cpRun, 0);
    check("R1 bypass", cpBypass, 0);
    check("R1 doorbell", cpDoorbell, 0);
    hostRead(2'd3, rd); check("R1 ctrl", rd, 8'h00);
    hostRead(2'd0, rd); check("R1 ptr lo", rd, 8'h00);
    hostRead(2'd1, rd); check("R1 ptr hi", rd, 8'h00);

    // R2 pointer byte loads
    setPtr(16'hC35A);
    hostRead(2'd0, rd); check("R2 lo", rd, 8'h5A);
    hostRead(2'd1, rd); check("R2 hi", rd, 8'hC3);
    hostWrite(2'd0, 8'h11);
    hostRead(2'd1, rd); check("R2 hi kept", rd, 8'hC3);
    hostRead(2'd0, rd); check("R2 lo new", rd, 8'h11);

    // R6 R7 R8 full control byte sweep against a model
    dbModel = 1'b0; intModel = 2'b00;
    for (int v = 0; v < 256; v++) begin
      hostWrite(2'd3, 8'(v));
      dbModel = dbModel | v[3];
      hostRead(2'd3, rd);
      check("R6 R7 R8 ctrl sweep", rd,
            {2'b00, intModel, dbModel, 3'(v & 7)});
      check("R6 run pin", cpRun, 16'(v & 1));
      check("R6 bypass pin", cpBypass, 16'((v >> 2) & 1));
    end
    // R7 ack clears doorbell
    cpDoorbellAck = 1'b1; @(negedge clk); cpDoorbellAck = 1'b0;
    check("R7 ack clears", cpDoorbell, 0);
    hostWrite(2'd3, 8'h08);
    check("R7 ring", cpDoorbell, 1);
    hostWrite(2'd3, 8'h00);
    hostRead(2'd3, rd); check("R7 write0 no effect", rd, 8'h08);
    cpDoorbellAck = 1'b1; @(negedge clk); cpDoorbellAck = 1'b0;
    hostRead(2'd3, rd); check("R7 ack readback", rd, 8'h00);

    // R3 R5 stream fill of whole memory
    hostWrite(2'd3, 8'h02);
    setPtr(16'h0000);
    for (int i = 0; i < DEPTH; i++) hostWrite(2'd2, pat(i));
    hostRead(2'd0, lo); hostRead(2'd1, hi);
    check("R5 carry to 0x0100", {hi, lo}, 16'h0100);
    for (int i = 0; i < DEPTH; i++) begin
      cpRead(MEM_AW'(i), rd); check("R3 cp sees host byte", rd, pat(i));
    end
    // R4 stream read
    setPtr(16'h0000);
    for (int i = 0; i < DEPTH; i++) begin
      hostRead(2'd2, rd); check("R4 stream read", rd, pat(i));
    end

    // R5 hold with advance off
    hostWrite(2'd3, 8'h00);
    setPtr(16'h0010);
    hostWrite(2'd2, 8'h77);
    hostRead(2'd0, rd); check("R5 hold after write", rd, 8'h10);
    hostRead(2'd2, rd); check("R4 read at pointer", rd, 8'h77);
    hostRead(2'd0, rd); check("R5 hold after read", rd, 8'h10);

    // R5 wrap at 0xFFFF
    hostWrite(2'd3, 8'h02);
    setPtr(16'hFFFF);
    hostWrite(2'd2, 8'h55);
    hostRead(2'd0, lo); hostRead(2'd1, hi);
    check("R5 wrap", {hi, lo}, 16'h0000);
    hostWrite(2'd3, 8'h00);

    // R8 R9 event flags
    cpIntSet = 2'b01; @(negedge clk); cpIntSet = 2'b00;
    check("R9 irq from flag0", hostIrq, 1);
    hostRead(2'd3, rd); check("R8 flag0 set", rd, 8'h10);
    hostWrite(2'd3, 8'h00);
    check("R8 write0 keeps flag", hostIrq, 1);
    hostWrite(2'd3, 8'h10);
    check("R8 w1c flag0", hostIrq, 0);
    cpIntSet = 2'b11; @(negedge clk); cpIntSet = 2'b00;
    hostWrite(2'd3, 8'h11);
    check("R6 run with ack", cpRun, 1);
    hostRead(2'd3, rd); check("R8 only flag1 left", rd, 8'h21);
    check("R9 irq from flag1", hostIrq, 1);
    hostWrite(2'd3, 8'h20);
    check("R9 irq low", hostIrq, 0);
    cpIntSet = 2'b01; hostWr = 1'b1; hostAddr = 2'd3; hostWdata = 8'h10;
    @(negedge clk);
    cpIntSet = 2'b00; hostWr = 1'b0;
    hostRead(2'd3, rd); check("R8 strobe beats clear", rd, 8'h10);
    hostWrite(2'd3, 8'h10);
    check("R8 cleared", hostIrq, 0);

    // R10 coprocessor port and collision
    cpWrite(8'h40, 8'hAB);
    setPtr(16'h0040);
    hostRead(2'd2, rd); check("R10 host sees cp byte", rd, 8'hAB);
    setPtr(16'h0041);
    hostWr = 1'b1; hostAddr = 2'd2; hostWdata = 8'h12;
    cpEn = 1'b1; cpWe = 1'b1; cpAddr = 8'h41; cpWdata = 8'h34;
    @(negedge clk);
    hostWr = 1'b0; cpEn = 1'b0; cpWe = 1'b0;
    cpRead(8'h41, rd); check("R10 host wins collision", rd, 8'h12);

    // R11 liveness handshake
    cpWrite(8'h05, 8'hFF);
    setPtr(16'h0005);
    hostRead(2'd2, rd); check("R11 alive read", rd, 8'hFF);
    hostWrite(2'd2, 8'h00);
    cpRead(8'h05, rd); check("R11 cleared", rd, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule